// File: doc/BRIEF.md
# Descriptor Ring Auto-Poll Timer

This block tells a DMA engine when to look at its transmit and receive descriptor rings again, so that software does not have to write a poll-demand register every time it hands a buffer to the hardware. It has two identical channels, receive and transmit, and each one produces a single-cycle poll request pulse. A pulse can have two causes. The first is a timer that fires once every programmed number of base cycles. The second is an explicit demand strobe.

Each channel has a 4-bit period and a long-cycle select bit. The base cycle depends on the link speed and on that select bit. It is one quantum (a parameter in clocks) at the fast link speed in short mode. It is 10 quanta at the slow link speed in short mode, 16 quanta at the fast speed in long mode, and 160 quanta at the slow speed in long mode. A period of zero turns off the automatic requests but leaves demands working.

While the DMA engine reports busy, requests are held back. They are released as a single pulse once busy clears. A demand restarts its channel's timer, and so does a write that changes that channel's field.

Top module: `ring_autopoll`

## Requirements
- R1: The 16-bit setting register has this layout: bit 12 is the transmit long-cycle select, bits 11:8 are the transmit period, bit 4 is the receive long-cycle select and bits 3:0 are the receive period. Reset loads the transmit period 0 and the receive period 1, both in short mode.
- R2: For a channel with period P > 0, an automatic pulse follows exactly P × L clocks after that channel's timer restarts, and then repeats every P × L clocks. L is QUANTUM_CLKS × 1 when short and fast, × 10 when short and slow, × 16 when long and fast, and × 160 when long and slow. The link is fast when `link_fast_i` = 1.
- R3: A channel whose period is 0 produces no automatic pulses.
- R4: A demand strobe that is sampled while not busy gives a poll pulse in the next cycle. The same strobe restarts that channel's timer.
- R5: The two channels are independent. Demands, settings and timer pulses on one channel never cause a pulse on the other.
- R6: While `dma_busy_i` is high at a clock edge, no pulse is issued. Requests that arrive during busy, however many there are, leave exactly one pulse, issued in the cycle after the first edge at which busy is low.
- R7: A setting write that changes a channel's period or long-cycle select restarts that channel's timer. A write that leaves the channel's field unchanged does not disturb its timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_fast_i | input | 1 | 1 = fast link speed, 0 = slow link speed |
| cfg_we_i | input | 1 | Write strobe for the setting register |
| cfg_wdata_i | input | 16 | Value to write to the setting register (layout in R1) |
| tx_demand_i | input | 1 | Explicit transmit poll demand |
| rx_demand_i | input | 1 | Explicit receive poll demand |
| dma_busy_i | input | 1 | DMA engine busy; requests are held while it is high |
| tx_poll_o | output | 1 | Transmit ring poll request pulse |
| rx_poll_o | output | 1 | Receive ring poll request pulse |

## Verification
A prescaler or period counter that is off by one moves the first automatic pulse after a demand away from exactly P × L clocks. That error is therefore seen on the very first interval, and the sweep measures that interval for every period and every base-cycle choice. A pending flag that sticks or gets lost shows up within one cycle of busy dropping: there is either an extra pulse or a missing one. A restart that fires on the wrong condition shifts the next pulse by a measurable number of clocks after a setting write.

// File: rtl/ap_pkg.sv
package ap_pkg;
  localparam int CFG_W   = 16;
  localparam int PER_W   = 4;
  localparam int NCH     = 2;
  localparam int CH_RX   = 0;
  localparam int CH_TX   = 1;
  localparam int CH_STEP = 8;
  localparam logic [CFG_W-1:0] CFG_RESET = 16'h0001;

  typedef struct packed {
    logic             long_sel;
    logic [PER_W-1:0] period;
  } chan_cfg_t;

  // channel ch occupies bits [8*ch+4 : 8*ch]
  function automatic chan_cfg_t field_of(input logic [CFG_W-1:0] w, input int ch);
    chan_cfg_t f;
    f.long_sel = w[ch*CH_STEP + PER_W];
    f.period   = w[ch*CH_STEP +: PER_W];
    return f;
  endfunction

  function automatic int base_mult(input logic long_sel, input logic fast);
    case ({long_sel, fast})
      2'b01:   return 1;
      2'b00:   return 10;
      2'b11:   return 16;
      default: return 160;
    endcase
  endfunction
endpackage

// File: rtl/ap_prescaler.sv
module ap_prescaler #(
  parameter int QUANTUM_CLKS = 640
) (
  input  logic clk,
  input  logic rst,
  input  logic restart_i,
  input  logic long_i,
  input  logic fast_i,
  output logic tick_o
);
  import ap_pkg::*;
  localparam int MAXLEN = QUANTUM_CLKS * 160;
  localparam int LW     = $clog2(MAXLEN + 1);

  logic [LW-1:0] cnt_q;
  logic [LW-1:0] last_w;

  assign last_w = LW'(QUANTUM_CLKS * base_mult(long_i, fast_i) - 1);
  // >= keeps the counter safe when the link speed shrinks the limit
  assign tick_o = (cnt_q >= last_w);

  always_ff @(posedge clk) begin
    if (rst || restart_i) cnt_q <= '0;
    else if (tick_o)      cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end

  a_r2_cnt_bounded: assert property (@(posedge clk) disable iff (rst)
    (cnt_q <= LW'(MAXLEN - 1)));
endmodule

// File: rtl/ap_period.sv
module ap_period #(
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart_i,
  input  logic          tick_i,
  input  logic [PW-1:0] period_i,
  output logic          fire_o
);
  logic [PW-1:0] cnt_q;
  logic          at_end;

  assign at_end = (cnt_q >= period_i - 1'b1);
  assign fire_o = tick_i && (period_i != '0) && at_end;

  always_ff @(posedge clk) begin
    if (rst || restart_i) cnt_q <= '0;
    else if (tick_i)      cnt_q <= at_end ? '0 : cnt_q + 1'b1;
  end

  a_r2_count_in_range: assert property (@(posedge clk) disable iff (rst)
    (period_i != '0) |-> (cnt_q < period_i));
endmodule

// File: rtl/ap_merge.sv
module ap_merge (
  input  logic clk,
  input  logic rst,
  input  logic timer_req_i,
  input  logic demand_i,
  input  logic busy_i,
  output logic poll_o
);
  logic pend_q;
  logic want;

  assign want = timer_req_i | demand_i | pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      poll_o <= 1'b0;
    end else if (busy_i) begin
      pend_q <= want;
      poll_o <= 1'b0;
    end else begin
      pend_q <= 1'b0;
      poll_o <= want;
    end
  end

  a_r6_busy_blocks: assert property (@(posedge clk) disable iff (rst)
    busy_i |=> !poll_o);
  a_r6_pending_release: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !busy_i) |=> (poll_o && !pend_q));
  a_r4_demand_served: assert property (@(posedge clk) disable iff (rst)
    (demand_i && !busy_i) |=> poll_o);
endmodule

// File: rtl/ring_autopoll.sv
module ring_autopoll #(
  parameter int QUANTUM_CLKS = 640
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        link_fast_i,
  input  logic        cfg_we_i,
  input  logic [15:0] cfg_wdata_i,
  input  logic        tx_demand_i,
  input  logic        rx_demand_i,
  input  logic        dma_busy_i,
  output logic        tx_poll_o,
  output logic        rx_poll_o
);
  import ap_pkg::*;

  logic [CFG_W-1:0] cfg_q;
  logic [NCH-1:0]   demand_w;
  logic [NCH-1:0]   poll_w;

  assign demand_w[CH_RX] = rx_demand_i;
  assign demand_w[CH_TX] = tx_demand_i;
  assign rx_poll_o       = poll_w[CH_RX];
  assign tx_poll_o       = poll_w[CH_TX];

  always_ff @(posedge clk) begin
    if (rst)           cfg_q <= CFG_RESET;
    else if (cfg_we_i) cfg_q <= cfg_wdata_i;
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    chan_cfg_t cur, nxt;
    logic      restart, tick, fire;

    assign cur     = field_of(cfg_q, ch);
    assign nxt     = field_of(cfg_wdata_i, ch);
    assign restart = demand_w[ch] | (cfg_we_i && (nxt != cur));

    ap_prescaler #(.QUANTUM_CLKS(QUANTUM_CLKS)) u_pre (
      .clk(clk), .rst(rst), .restart_i(restart),
      .long_i(cur.long_sel), .fast_i(link_fast_i), .tick_o(tick));

    ap_period #(.PW(PER_W)) u_per (
      .clk(clk), .rst(rst), .restart_i(restart),
      .tick_i(tick), .period_i(cur.period), .fire_o(fire));

    ap_merge u_mrg (
      .clk(clk), .rst(rst), .timer_req_i(fire), .demand_i(demand_w[ch]),
      .busy_i(dma_busy_i), .poll_o(poll_w[ch]));

    a_r3_zero_silent: assert property (@(posedge clk) disable iff (rst)
      (cur.period == '0) |-> !fire);
    a_r2_fire_on_tick: assert property (@(posedge clk) disable iff (rst)
      fire |-> tick);
  end
endmodule

// File: tb/sim_ring_autopoll.sv
module sim_ring_autopoll;
  localparam int Q = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        link_fast = 1'b1;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic        tx_dem = 1'b0, rx_dem = 1'b0, busy = 1'b0;
  logic        tx_poll, rx_poll;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  ring_autopoll #(.QUANTUM_CLKS(Q)) u0 (
    .clk(clk), .rst(rst), .link_fast_i(link_fast), .cfg_we_i(cfg_we),
    .cfg_wdata_i(cfg_wdata), .tx_demand_i(tx_dem), .rx_demand_i(rx_dem),
    .dma_busy_i(busy), .tx_poll_o(tx_poll), .rx_poll_o(rx_poll));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int mult(input int lng, input int fst);
    if (lng == 0) return (fst != 0) ? 1 : 10;
    return (fst != 0) ? 16 : 160;
  endfunction

  function automatic logic poll_of(input int ch);
    return (ch == 0) ? rx_poll : tx_poll;
  endfunction

  task automatic set_dem(input int ch, input logic v);
    if (ch == 0) rx_dem = v; else tx_dem = v;
  endtask

  task automatic write_cfg(input logic [15:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  // demand, then measure clocks to first automatic pulse
  task automatic sweep_case(input int ch, input int lng, input int fst, input int p);
    int gap, lim, first;
    bit other;
    gap = p * Q * mult(lng, fst);
    lim = (p == 0) ? 400 : gap + 4;
    first = -1;
    other = 0;
    link_fast = fst[0];
    if (ch == 0) write_cfg(16'((lng << 4) | p));
    else         write_cfg(16'((lng << 12) | (p << 8)));
    @(negedge clk); set_dem(ch, 1'b1);
    @(negedge clk); set_dem(ch, 1'b0);
    chk(poll_of(ch) == 1'b1, "R4 demand pulse", int'(poll_of(ch)), 1);
    if (poll_of(1 - ch)) other = 1;
    for (int k = 1; k <= lim; k++) begin
      @(negedge clk);
      if (poll_of(1 - ch)) other = 1;
      if (poll_of(ch)) begin first = k; break; end
    end
    if (p == 0) chk(first == -1, "R3 period zero silent", first, -1);
    else        chk(first == gap, "R2 interval P*L", first, gap);
    chk(other == 0, "R5 other channel quiet", int'(other), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int nrx, ntx, first;
    repeat (3) @(negedge clk);
    chk(rx_poll == 1'b0 && tx_poll == 1'b0, "R1 reset outputs low", int'(rx_poll | tx_poll), 0);
    rst = 1'b0;
    // R1: default rx period 1 short, fast link -> L=2, tx off
    nrx = 0; ntx = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      nrx += int'(rx_poll);
      ntx += int'(tx_poll);
    end
    chk(nrx == 10, "R1 default rx period", nrx, 10);
    chk(ntx == 0, "R1 default tx off", ntx, 0);

    // R2/R3/R4/R5 sweeps
    for (int l = 0; l < 2; l++)
      for (int f = 0; f < 2; f++)
        for (int p = 0; p < 16; p++) sweep_case(0, l, f, p);
    for (int l = 0; l < 2; l++)
      for (int p = 0; p < 16; p++) sweep_case(1, l, 1, p);
    sweep_case(1, 0, 0, 1);
    sweep_case(1, 0, 0, 7);
    sweep_case(1, 1, 0, 2);

    // R6: busy holds and collapses requests
    link_fast = 1'b1;
    write_cfg(16'h0000);
    repeat (3) @(negedge clk);
    busy = 1'b1;
    nrx = 0; ntx = 0;
    for (int i = 0; i < 9; i++) begin
      @(negedge clk);
      rx_dem = (i % 3 == 0);
      tx_dem = (i == 4);
      nrx += int'(rx_poll);
      ntx += int'(tx_poll);
    end
    @(negedge clk); rx_dem = 1'b0; tx_dem = 1'b0;
    nrx += int'(rx_poll); ntx += int'(tx_poll);
    chk(nrx + ntx == 0, "R6 no pulse while busy", nrx + ntx, 0);
    busy = 1'b0;
    @(negedge clk);
    chk(rx_poll == 1'b1, "R6 rx released", int'(rx_poll), 1);
    chk(tx_poll == 1'b1, "R6 tx released", int'(tx_poll), 1);
    nrx = 0; ntx = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      nrx += int'(rx_poll);
      ntx += int'(tx_poll);
    end
    chk(nrx + ntx == 0, "R6 collapsed to one", nrx + ntx, 0);

    // R6: timer pulse during busy also held
    write_cfg(16'h0001);
    busy = 1'b1;
    repeat (6) @(negedge clk);
    chk(rx_poll == 1'b0, "R6 timer held", int'(rx_poll), 0);
    busy = 1'b0;
    @(negedge clk);
    chk(rx_poll == 1'b1, "R6 timer released", int'(rx_poll), 1);

    // R7: unchanged field keeps the timer, changed field restarts it
    write_cfg(16'h0003);          // rx P=3, L=2 -> gap 6
    @(negedge clk); rx_dem = 1'b1;
    @(negedge clk); rx_dem = 1'b0; // k=0
    repeat (2) @(negedge clk);     // k=2
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = 16'h1003; // k=3, write at edge 4
    @(negedge clk); cfg_we = 1'b0; // k=4
    @(negedge clk);                // k=5
    chk(rx_poll == 1'b0, "R7 no early pulse", int'(rx_poll), 0);
    @(negedge clk);                // k=6
    chk(rx_poll == 1'b1, "R7 unchanged keeps timer", int'(rx_poll), 1);
    cfg_we = 1'b1; cfg_wdata = 16'h1002; // rx P=2 -> gap 4 from write edge
    first = -1;
    @(negedge clk); cfg_we = 1'b0;       // j=0
    for (int j = 1; j <= 8; j++) begin
      @(negedge clk);
      if (rx_poll) begin first = j; break; end
    end
    chk(first == 4, "R7 change restarts timer", first, 4);
    chk(tx_poll == 1'b0, "R5 tx untouched", int'(tx_poll), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule